// File: doc/BRIEF.md
# Gather/Scatter Access Sequencer

The sequencer moves one vector between registers and memory when the elements are not adjacent in memory. Each element address is a scalar base plus that lane's offset, taken from an offset vector. A load fills a result vector lane by lane. A store writes each lane of a store vector back to memory. The memory element may be narrower than the vector lane. Loaded values are then zero- or sign-extended to the lane width, and stored values are cut down to their low bytes.

The sequencer normally issues one memory access per element. The offset generator can attach a one-bit hint that promises the offsets are consecutive and never wrap. When the hint is set at start, the sequencer instead issues four beat-sized contiguous accesses, which saves up to twelve accesses for byte lanes. The hint is volatile. An abort asserted while an operation is in flight drops the hint, throws away any pending response and restarts the whole operation from lane 0 in per-element mode. This matches the recovery after an exception, where the hint is not preserved.

The memory port allows one request at a time. A request is a one-cycle pulse carrying address, size, write enable and write data. It is completed by a one-cycle response strobe, which carries read data for loads.

Top module: `gather_scatter_seq`

## Requirements
- R1: After reset, `done`, `busy` and `memReq` are 0 and `result` is all zeros.
- R2: With the hint clear at start, the sequencer issues one access per lane, in lane order from lane 0. There are 16, 8 or 4 accesses for lane size codes 0, 1 and 2. Lane i uses address `baseAddr` + (lane i of `offsetVec`, zero-extended) and `memSize` equal to the memory size code. Size codes are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes, and lane i occupies bytes i*laneBytes upward of a vector.
- R3: For a load, each lane takes the low memBytes bytes of its response data, with lane bytes little-endian. When `signExt` is 1, the remaining upper lane bytes copy the top bit of the memory element; otherwise they are zero.
- R4: For a store, `memWe` is 1 and each access writes the low memBytes bytes of its lane. Lanes are written in lane order, so a later lane wins when two addresses coincide. `result` reads all zeros after a store.
- R5: With the hint set at start, exactly four accesses are issued. Access k (k = 0 to 3) goes to `baseAddr` + lane-0 offset + k*B, where B = memBytes*4/laneBytes, and its size code is log2(B). Its bytes hold 4/laneBytes consecutive elements, lowest lane in the lowest bytes.
- R6: `done` is a one-cycle pulse in the cycle after the final memory response. `busy` is 1 from the cycle after `start` until `done`, and 0 while `done` is high.
- R7: An `abort` during an operation drops the hint and discards any response still outstanding. The operation then restarts from lane 0 in per-element mode, and the final result and memory contents match an uninterrupted operation.
- R8: A size code of 3 is taken as 2. A memory size code larger than the lane size code is reduced to the lane size code.
- R9: `start` while busy and `abort` while idle are ignored.
- R10: `memReq` is a one-cycle pulse, and no new request is made until the previous one has its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| isStore | input | 1 | 1 = scatter store, 0 = gather load |
| hint | input | 1 | Offsets are consecutive and wrap-free |
| abort | input | 1 | Drop hint and restart in per-element mode |
| baseAddr | input | 32 | Scalar base address |
| offsetVec | input | 128 | Per-lane byte offsets, lane-size fields |
| storeVec | input | 128 | Data vector for stores |
| memSizeSel | input | 2 | Memory element size code |
| laneSizeSel | input | 2 | Vector lane size code |
| signExt | input | 1 | Sign-extend loaded elements |
| memReq | output | 1 | Memory request pulse |
| memWe | output | 1 | Request is a write |
| memAddr | output | 32 | Request byte address |
| memSize | output | 2 | Request size code |
| memWdata | output | 32 | Write data, low bytes first |
| memRvalid | input | 1 | Memory response strobe |
| memRdata | input | 32 | Read data for the response |
| result | output | 128 | Gathered vector |
| busy | output | 1 | Operation in flight |
| done | output | 1 | Operation complete pulse |

## Verification
The bench first runs gathers and scatters with random offsets. Here the results must come only from per-lane addressing and lane-ordered overwrites. It then repeats them with hinted, consecutive offsets, which give the same data through four packed beats. Comparing the two separates a packing or beat-address fault from a lane-indexing fault. Directed cases then cover:
- negative bytes under sign extension;
- the size code clamps;
- an abort in the middle of both a hinted load and a per-element store, which shows whether the restart really falls back to per-element mode;
- the two inputs that must be ignored.

// File: rtl/gsseq_pkg.sv
package gsseq_pkg;
  localparam int GS_IDX_W = 8;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} gsState_e;

  typedef struct packed {
    logic                latchCfg;
    logic                wrRes;
    logic                contig;
    logic [GS_IDX_W-1:0] idx;
  } gsStrobe_t;

  function automatic logic [1:0] clampCode(input logic [1:0] code, input logic [1:0] maxCode);
    return (code > maxCode) ? maxCode : code;
  endfunction
endpackage

// File: rtl/gsseq_datapath.sv
module gsseq_datapath
  import gsseq_pkg::*;
#(
  parameter int BEAT_BYTES = 4,
  parameter int BEATS      = 4,
  parameter int ADDR_W     = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  gsStrobe_t                   strb,
  input  logic                        isStore,
  input  logic [ADDR_W-1:0]           baseAddr,
  input  logic [8*BEAT_BYTES*BEATS-1:0] offsetVec,
  input  logic [8*BEAT_BYTES*BEATS-1:0] storeVec,
  input  logic [1:0]                  memSizeSel,
  input  logic [1:0]                  laneSizeSel,
  input  logic                        signExt,
  input  logic [8*BEAT_BYTES-1:0]     memRdata,
  output logic                        memWe,
  output logic [ADDR_W-1:0]           memAddr,
  output logic [1:0]                  memSize,
  output logic [8*BEAT_BYTES-1:0]     memWdata,
  output logic [8*BEAT_BYTES*BEATS-1:0] result,
  output logic [1:0]                  laneCodeQ
);
  localparam int VEC_BYTES = BEAT_BYTES * BEATS;
  localparam int VEC_W     = 8 * VEC_BYTES;
  localparam int BEAT_W    = 8 * BEAT_BYTES;
  localparam int MAXC      = $clog2(BEAT_BYTES);
  localparam logic [1:0] MAXC_L = 2'(MAXC);

  logic [ADDR_W-1:0] baseQ;
  logic [VEC_W-1:0]  offQ, stQ, resQ, resNext;
  logic [1:0]        memCodeQ;
  logic              sgnQ, weQ;
  logic [1:0]        laneClamp, memClamp;
  logic [BEAT_W-1:0] off0, offIdx, wdata;
  int                idxInt, memBytes, laneBytes, shiftPB, cnt, first, accBytes;

  assign laneClamp = clampCode(laneSizeSel, MAXC_L);
  assign memClamp  = clampCode(memSizeSel, laneClamp);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ     <= '0;
      offQ      <= '0;
      stQ       <= '0;
      memCodeQ  <= '0;
      laneCodeQ <= '0;
      sgnQ      <= 1'b0;
      weQ       <= 1'b0;
    end else if (strb.latchCfg) begin
      baseQ     <= baseAddr;
      offQ      <= offsetVec;
      stQ       <= storeVec;
      memCodeQ  <= memClamp;
      laneCodeQ <= laneClamp;
      sgnQ      <= signExt;
      weQ       <= isStore;
    end
  end

  always_comb begin
    idxInt    = int'(strb.idx);
    memBytes  = 1 << memCodeQ;
    laneBytes = 1 << laneCodeQ;
    shiftPB   = MAXC - int'(laneCodeQ);
    cnt       = strb.contig ? (1 << shiftPB) : 1;
    first     = strb.contig ? (idxInt << shiftPB) : idxInt;
    accBytes  = memBytes * cnt;
  end

  // lane offsets: lane 0 for beat mode, current lane for element mode
  always_comb begin
    off0   = '0;
    offIdx = '0;
    for (int b = 0; b < BEAT_BYTES; b++) begin
      if (b < laneBytes) begin
        off0[8*b +: 8] = offQ[8*b +: 8];
        if ((idxInt * laneBytes + b) < VEC_BYTES)
          offIdx[8*b +: 8] = offQ[8*(idxInt * laneBytes + b) +: 8];
      end
    end
  end

  // store data: element j of this access sits at bytes j*memBytes upward
  always_comb begin
    wdata = '0;
    for (int b = 0; b < BEAT_BYTES; b++) begin
      if (((b >> memCodeQ) < cnt) &&
          (((first + (b >> memCodeQ)) * laneBytes + (b & (memBytes - 1))) < VEC_BYTES))
        wdata[8*b +: 8] = stQ[8*((first + (b >> memCodeQ)) * laneBytes + (b & (memBytes - 1))) +: 8];
    end
  end

  // load data: place and extend each returned element into its lane
  always_comb begin
    resNext = resQ;
    for (int v = 0; v < VEC_BYTES; v++) begin
      if (((v >> laneCodeQ) >= first) && ((v >> laneCodeQ) < first + cnt)) begin
        if ((v & (laneBytes - 1)) < memBytes)
          resNext[8*v +: 8] = memRdata[8*(((v >> laneCodeQ) - first) * memBytes + (v & (laneBytes - 1))) +: 8];
        else
          resNext[8*v +: 8] = (sgnQ && memRdata[8*(((v >> laneCodeQ) - first) * memBytes + memBytes) - 1])
                              ? 8'hFF : 8'h00;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    resQ <= '0;
    else if (strb.latchCfg)       resQ <= '0;
    else if (strb.wrRes && !weQ)  resQ <= resNext;
  end

  assign memWe    = weQ;
  assign memWdata = wdata;
  assign memSize  = strb.contig ? (memCodeQ + (MAXC_L - laneCodeQ)) : memCodeQ;
  assign memAddr  = strb.contig ? (baseQ + ADDR_W'(off0) + ADDR_W'(idxInt * accBytes))
                                : (baseQ + ADDR_W'(offIdx));
  assign result   = resQ;

  // R8: the latched memory element never exceeds the latched lane
  p_code_order_r8: assert property (@(posedge clk) disable iff (!rstN)
    memCodeQ <= laneCodeQ);
endmodule

// File: rtl/gsseq_ctrl.sv
module gsseq_ctrl
  import gsseq_pkg::*;
#(
  parameter int BEAT_BYTES = 4,
  parameter int BEATS      = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       hint,
  input  logic       abort,
  input  logic       memRvalid,
  input  logic [1:0] laneCode,
  output gsStrobe_t  strb,
  output logic       memReq,
  output logic       busy,
  output logic       done
);
  localparam int VEC_BYTES = BEAT_BYTES * BEATS;
  localparam logic [GS_IDX_W-1:0] BEAT_LAST = GS_IDX_W'(BEATS - 1);

  gsState_e            state;
  logic [GS_IDX_W-1:0] idxQ, lastIdx;
  logic                contigQ, drainQ;

  assign lastIdx = contigQ ? BEAT_LAST : GS_IDX_W'((VEC_BYTES >> laneCode) - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      idxQ    <= '0;
      contigQ <= 1'b0;
      drainQ  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state   <= S_ISSUE;
          idxQ    <= '0;
          contigQ <= hint;
          drainQ  <= 1'b0;
        end
        S_ISSUE: if (abort) begin
          idxQ    <= '0;
          contigQ <= 1'b0;
        end else begin
          state <= S_WAIT;
        end
        S_WAIT: if (memRvalid) begin
          if (abort || drainQ) begin
            idxQ    <= '0;
            contigQ <= 1'b0;
            drainQ  <= 1'b0;
            state   <= S_ISSUE;
          end else if (idxQ == lastIdx) begin
            state <= S_DONE;
          end else begin
            idxQ  <= idxQ + 1'b1;
            state <= S_ISSUE;
          end
        end else if (abort) begin
          contigQ <= 1'b0;
          drainQ  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign strb.latchCfg = (state == S_IDLE) && start;
  assign strb.wrRes    = (state == S_WAIT) && memRvalid && !abort && !drainQ;
  assign strb.contig   = contigQ;
  assign strb.idx      = idxQ;
  assign memReq        = (state == S_ISSUE) && !abort;
  assign busy          = (state == S_ISSUE) || (state == S_WAIT);
  assign done          = (state == S_DONE);

  p_req_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_after_resp_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(memRvalid));
  p_abort_drops_hint_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && abort) |=> !strb.contig);
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !abort && !memRvalid) |=> ($stable(strb.idx) && busy));
endmodule

// File: rtl/gather_scatter_seq.sv
module gather_scatter_seq
  import gsseq_pkg::*;
#(
  parameter int BEAT_BYTES = 4,
  parameter int BEATS      = 4,
  parameter int ADDR_W     = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           start,
  input  logic                           isStore,
  input  logic                           hint,
  input  logic                           abort,
  input  logic [ADDR_W-1:0]              baseAddr,
  input  logic [8*BEAT_BYTES*BEATS-1:0]  offsetVec,
  input  logic [8*BEAT_BYTES*BEATS-1:0]  storeVec,
  input  logic [1:0]                     memSizeSel,
  input  logic [1:0]                     laneSizeSel,
  input  logic                           signExt,
  output logic                           memReq,
  output logic                           memWe,
  output logic [ADDR_W-1:0]              memAddr,
  output logic [1:0]                     memSize,
  output logic [8*BEAT_BYTES-1:0]        memWdata,
  input  logic                           memRvalid,
  input  logic [8*BEAT_BYTES-1:0]        memRdata,
  output logic [8*BEAT_BYTES*BEATS-1:0]  result,
  output logic                           busy,
  output logic                           done
);
  gsStrobe_t  strb;
  logic [1:0] laneCode;

  gsseq_ctrl #(.BEAT_BYTES(BEAT_BYTES), .BEATS(BEATS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .hint(hint), .abort(abort),
    .memRvalid(memRvalid), .laneCode(laneCode), .strb(strb),
    .memReq(memReq), .busy(busy), .done(done)
  );

  gsseq_datapath #(.BEAT_BYTES(BEAT_BYTES), .BEATS(BEATS), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .isStore(isStore), .baseAddr(baseAddr),
    .offsetVec(offsetVec), .storeVec(storeVec), .memSizeSel(memSizeSel),
    .laneSizeSel(laneSizeSel), .signExt(signExt), .memRdata(memRdata),
    .memWe(memWe), .memAddr(memAddr), .memSize(memSize), .memWdata(memWdata),
    .result(result), .laneCodeQ(laneCode)
  );
endmodule

// File: tb/gather_scatter_seq_test.sv
module gather_scatter_seq_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0, isStore = 1'b0, hint = 1'b0, abort = 1'b0, signExt = 1'b0;
  logic [31:0]  baseAddr = '0;
  logic [127:0] offsetVec = '0, storeVec = '0;
  logic [1:0]   memSizeSel = '0, laneSizeSel = '0;
  logic         memReq, memWe, memRvalid = 1'b0, busy, done;
  logic [31:0]  memAddr, memWdata, memRdata = '0;
  logic [1:0]   memSize;
  logic [127:0] result;

  always #5 clk = ~clk;

  gather_scatter_seq uut (
    .clk(clk), .rstN(rstN), .start(start), .isStore(isStore), .hint(hint), .abort(abort),
    .baseAddr(baseAddr), .offsetVec(offsetVec), .storeVec(storeVec),
    .memSizeSel(memSizeSel), .laneSizeSel(laneSizeSel), .signExt(signExt),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memSize(memSize),
    .memWdata(memWdata), .memRvalid(memRvalid), .memRdata(memRdata),
    .result(result), .busy(busy), .done(done)
  );

  int nChecks = 0, nFails = 0, monChecks = 0, monFails = 0;
  logic [7:0]  memArr [0:1023];
  logic [7:0]  shadow [0:1023];
  logic [31:0] accAddr [0:16383];
  logic [1:0]  accSize [0:16383];
  logic        accWe   [0:16383];
  int          accCnt = 0, cyc = 0, lastResp = -10, waitCnt = 0;

  // memory model: one request at a time, latency 1..3 cycles
  always @(posedge clk) begin
    logic [31:0] rd;
    memRvalid <= 1'b0;
    if (waitCnt == 1) begin
      memRvalid <= 1'b1;
      waitCnt   <= 0;
    end else if (waitCnt > 1) begin
      waitCnt <= waitCnt - 1;
    end
    if (memReq) begin
      for (int b = 0; b < 4; b++) rd[8*b +: 8] = memArr[(memAddr + 32'(b)) & 32'd1023];
      memRdata <= rd;
      waitCnt  <= 1 + int'($urandom % 3);
      if (memWe)
        for (int b = 0; b < (1 << memSize); b++)
          memArr[(memAddr + 32'(b)) & 32'd1023] <= memWdata[8*b +: 8];
    end
  end

  // port monitor: access log, R10 outstanding rule, R6 done timing
  always @(posedge clk) begin
    if (rstN) begin
      if (memReq) begin
        monChecks++;
        if (waitCnt != 0 || memRvalid) begin
          monFails++;
          $display("FAIL R10 request while outstanding actual=1 expected=0");
        end
        accAddr[accCnt % 16384] = memAddr;
        accSize[accCnt % 16384] = memSize;
        accWe[accCnt % 16384]   = memWe;
        accCnt++;
      end
      if (memRvalid) lastResp = cyc;
      if (done) begin
        monChecks++;
        if (cyc != lastResp + 1) begin
          monFails++;
          $display("FAIL R6 done edge actual=%0d expected=%0d", cyc, lastResp + 1);
        end
      end
    end
    cyc++;
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] laneOff(logic [127:0] offs, int i, int lb);
    logic [31:0] v = '0;
    for (int b = 0; b < lb; b++) v[8*b +: 8] = offs[8*(i*lb + b) +: 8];
    return v;
  endfunction

  function automatic int effLane(logic [1:0] ls);
    return (ls == 2'd3) ? 2 : int'(ls);
  endfunction

  function automatic int effMem(logic [1:0] ms, logic [1:0] ls);
    int lc = effLane(ls);
    int mc = (ms == 2'd3) ? 2 : int'(ms);
    return (mc > lc) ? lc : mc;
  endfunction

  function automatic logic [127:0] expGather(logic [31:0] base, logic [127:0] offs, int mc, int lc, bit sg);
    logic [127:0] r = '0;
    int lb = 1 << lc;
    int mb = 1 << mc;
    for (int i = 0; i < (16 >> lc); i++) begin
      logic [31:0] a;
      logic [31:0] v;
      a = base + laneOff(offs, i, lb);
      v = '0;
      for (int b = 0; b < mb; b++) v[8*b +: 8] = memArr[(a + 32'(b)) & 32'd1023];
      if (sg && v[8*mb - 1]) for (int b = mb; b < 4; b++) v[8*b +: 8] = 8'hFF;
      for (int b = 0; b < lb; b++) r[8*(i*lb + b) +: 8] = v[8*b +: 8];
    end
    return r;
  endfunction

  task automatic applyShadow(logic [31:0] base, logic [127:0] offs, logic [127:0] wd, int mc, int lc);
    int lb = 1 << lc;
    for (int i = 0; i < (16 >> lc); i++) begin
      logic [31:0] a;
      a = base + laneOff(offs, i, lb);
      for (int b = 0; b < (1 << mc); b++) shadow[(a + 32'(b)) & 32'd1023] = wd[8*(i*lb + b) +: 8];
    end
  endtask

  task automatic checkMem(input string req);
    int bad = -1;
    for (int k = 0; k < 1024; k++) if (memArr[k] !== shadow[k] && bad < 0) bad = k;
    chk(bad < 0, req, (bad < 0) ? 128'd0 : {96'd0, 24'd0, memArr[bad]},
                      (bad < 0) ? 128'd0 : {96'd0, 24'd0, shadow[bad]});
  endtask

  task automatic checkAcc(int from, logic [31:0] base, logic [127:0] offs, int mc, int lc,
                          bit contig, bit st, string req);
    int n  = contig ? 4 : (16 >> lc);
    int lb = 1 << lc;
    int ab = (1 << mc) * (contig ? (4 >> lc) : 1);
    int code = mc + (contig ? (2 - lc) : 0);
    bit ok = ((accCnt - from) == n);
    logic [31:0] badA = '0, badE = '0;
    if (ok) for (int k = 0; k < n; k++) begin
      logic [31:0] e;
      e = contig ? (base + laneOff(offs, 0, lb) + 32'(k*ab)) : (base + laneOff(offs, k, lb));
      if (ok && (accAddr[(from+k) % 16384] !== e || accSize[(from+k) % 16384] !== 2'(code) ||
                 accWe[(from+k) % 16384] !== st)) begin
        ok = 0; badA = accAddr[(from+k) % 16384]; badE = e;
      end
    end
    chk(ok, req, {32'(accCnt - from), badA}, {32'(n), badE});
  endtask

  task automatic startOp(bit st, bit h, logic [31:0] base, logic [127:0] offs, logic [127:0] wd,
                         logic [1:0] ms, logic [1:0] ls, bit sg);
    @(negedge clk);
    isStore = st; hint = h; baseAddr = base; offsetVec = offs; storeVec = wd;
    memSizeSel = ms; laneSizeSel = ls; signExt = sg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R6 busy after start", {127'd0, busy}, 128'd1);
  endtask

  task automatic waitDone();
    while (done !== 1'b1) @(negedge clk);
  endtask

  function automatic logic [127:0] buildOffs(bit h, int mc, int lc);
    logic [127:0] o = '0;
    int lb = 1 << lc;
    logic [31:0] o0 = (lc == 0) ? ($urandom % 200) : ($urandom % 400);
    for (int i = 0; i < (16 >> lc); i++) begin
      logic [31:0] v;
      v = h ? (o0 + 32'(i * (1 << mc))) : ((lc == 0) ? ($urandom & 32'hFF) : ($urandom & 32'h1FF));
      for (int b = 0; b < lb; b++) o[8*(i*lb + b) +: 8] = v[8*b +: 8];
    end
    return o;
  endfunction

  task automatic runOp(bit st, bit h, logic [31:0] base, logic [127:0] offs, logic [127:0] wd,
                       logic [1:0] ms, logic [1:0] ls, bit sg, string tag);
    int mc = effMem(ms, ls);
    int lc = effLane(ls);
    int from = accCnt;
    logic [127:0] exp;
    if (st) applyShadow(base, offs, wd, mc, lc);
    exp = st ? 128'd0 : expGather(base, offs, mc, lc, sg);
    startOp(st, h, base, offs, wd, ms, ls, sg);
    waitDone();
    if (st) begin
      chk(result === 128'd0, "R4 store result zero", result, 128'd0);
      checkMem({tag, " R4 scatter memory"});
    end else begin
      chk(result === exp, {tag, " R3 gather result"}, result, exp);
    end
    checkAcc(from, base, offs, mc, lc, h, st, h ? {tag, " R5 beat accesses"} : {tag, " R2 element accesses"});
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < 1024; k++) begin
      memArr[k] = 8'($urandom);
      shadow[k] = memArr[k];
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(done === 1'b0 && busy === 1'b0 && memReq === 1'b0, "R1 reset outputs",
        {125'd0, done, busy, memReq}, 128'd0);
    chk(result === 128'd0, "R1 reset result", result, 128'd0);

    // R3 directed sign extension: 32-bit lanes, byte elements, hinted
    memArr[100] = 8'hF0; shadow[100] = 8'hF0;
    memArr[101] = 8'h05; shadow[101] = 8'h05;
    runOp(1'b0, 1'b1, 32'd100, {32'd3, 32'd2, 32'd1, 32'd0}, '0, 2'd0, 2'd2, 1'b1, "sign");
    chk(result[63:0] === 64'h00000005_FFFFFFF0, "R3 sign extend lanes", {64'd0, result[63:0]},
        {64'd0, 64'h00000005_FFFFFFF0});
    runOp(1'b0, 1'b0, 32'd100, {32'd3, 32'd2, 32'd1, 32'd0}, '0, 2'd0, 2'd2, 1'b0, "zero");
    chk(result[31:0] === 32'h000000F0, "R3 zero extend lane0", {96'd0, result[31:0]}, 128'h0F0);

    // R8 size clamps
    runOp(1'b0, 1'b0, 32'd40, buildOffs(1'b0, 2, 2), '0, 2'd3, 2'd3, 1'b0, "R8 code3");
    runOp(1'b0, 1'b0, 32'd40, buildOffs(1'b0, 0, 0), '0, 2'd2, 2'd0, 1'b0, "R8 mem>lane");
    runOp(1'b1, 1'b1, 32'd60, buildOffs(1'b1, 1, 1), {4{32'($urandom)}}, 2'd3, 2'd1, 1'b0, "R8 store");

    // random mix of modes
    for (int t = 0; t < 60; t++) begin
      logic [1:0] ls, ms;
      bit h, st;
      ls = 2'($urandom % 4);
      ms = 2'($urandom % 4);
      h  = 1'($urandom % 2);
      st = 1'($urandom % 2);
      runOp(st, h, $urandom % 256, buildOffs(h, effMem(ms, ls), effLane(ls)),
            {$urandom, $urandom, $urandom, $urandom}, ms, ls, 1'($urandom % 2), "rand");
    end

    // R7 abort during a hinted load
    begin
      logic [127:0] o, e;
      int a;
      o = buildOffs(1'b1, 0, 1);
      e = expGather(32'd20, o, 0, 1, 1'b1);
      startOp(1'b0, 1'b1, 32'd20, o, '0, 2'd0, 2'd1, 1'b1);
      while (accCnt < a + 2 && a >= 0) begin
        a = -1;
      end
      a = accCnt;
      while (accCnt < a + 2) @(negedge clk);
      a = accCnt;
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      waitDone();
      chk(result === e, "R7 abort load result", result, e);
      checkAcc(a, 32'd20, o, 0, 1, 1'b0, 1'b0, "R7 abort falls back to elements");
    end

    // R7 abort during a per-element store
    begin
      logic [127:0] o, w;
      int a;
      o = buildOffs(1'b0, 1, 2);
      w = {$urandom, $urandom, $urandom, $urandom};
      applyShadow(32'd200, o, w, 1, 2);
      startOp(1'b1, 1'b0, 32'd200, o, w, 2'd1, 2'd2, 1'b0);
      a = accCnt;
      while (accCnt < a + 1) @(negedge clk);
      a = accCnt;
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      waitDone();
      checkMem("R7 abort store memory");
      checkAcc(a, 32'd200, o, 1, 2, 1'b0, 1'b1, "R7 abort store restart");
    end

    // R9 start while busy is ignored
    begin
      logic [127:0] o, e;
      int a, from;
      o = buildOffs(1'b0, 2, 2);
      e = expGather(32'd8, o, 2, 2, 1'b0);
      from = accCnt;
      startOp(1'b0, 1'b0, 32'd8, o, '0, 2'd2, 2'd2, 1'b0);
      a = accCnt;
      while (accCnt < a + 1) @(negedge clk);
      baseAddr = 32'd300; hint = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      waitDone();
      chk(result === e, "R9 start while busy result", result, e);
      checkAcc(from, 32'd8, o, 2, 2, 1'b0, 1'b0, "R9 start while busy accesses");
    end

    // R9 abort while idle is ignored
    begin
      int a;
      logic [127:0] keep;
      repeat (2) @(negedge clk);
      a = accCnt;
      keep = result;
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      repeat (4) @(negedge clk);
      chk(accCnt == a && busy === 1'b0, "R9 idle abort no request", 128'(accCnt - a), 128'd0);
      chk(result === keep, "R9 idle abort result kept", result, keep);
    end

    repeat (3) @(negedge clk);
    nChecks += monChecks;
    nFails  += monFails;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks += monChecks + 1;
    nFails  += monFails + 1;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule